// File: doc/BRIEF.md
# Receive Line Status Tracker with Per-Character Error Tags

This block sits between a serial receiver and the CPU-facing register file of a UART. Each received character is stored in a small receive queue with three error tags: a parity error, a framing error and a break. A tag is reported in the line status byte only while its own character is at the head of the queue. The CPU therefore always sees the error that belongs to the character it is about to read, and not one that belongs to a character still waiting behind it.

The block also builds the rest of the line status byte. It keeps an overrun flag for characters that arrive when the queue is full. It passes through two transmit-side emptiness indications. It forms an aggregate error bit in queue mode, which stays set across a status read while any later entry still carries a tag. A line status interrupt request is raised when the enable is high and any of the four error bits is set.

In queue mode the queue holds `DEPTH` entries. In single-character mode it holds one entry, like a plain holding register. Baud-rate generation and the serial shifters belong to neighbouring blocks.

Top module: `rx_err_status`

## Requirements
- R1: Status bit 0 (data ready) is 1 exactly when the receive queue holds at least one character. A character pushed into an empty queue makes it 1 from the clock edge that accepts the push.
- R2: Characters leave in arrival order on `rxDataOut`, which shows the head character. `rxDataOut` is 0 when the queue is empty. The capacity is `DEPTH` (16) when `fifoMode` is 1 and one character when `fifoMode` is 0. A pop on an empty queue has no effect.
- R3: When `rxPush` arrives while the queue is full and no pop is made in the same cycle, the character is discarded and status bit 1 (overrun) is set. A status read clears it, unless a new overrun occurs in the same cycle.
- R4: Status bits 2 (parity), 3 (framing) and 4 (break) show the tags that were pushed with the head character, from `rxTags` bit 0, bit 1 and bit 2 respectively. The tags of characters behind the head never show in these bits, and the bits are 0 when the queue is empty.
- R5: A status read with a non-empty queue and no pop clears the tags of the head character, so bits 2 to 4 read 0 afterwards. The character itself stays in place: data ready and `rxDataOut` are unchanged.
- R6: Status bit 7 is 1 in queue mode while at least one stored character still carries any tag. It stays 1 after a status read while entries behind the head have tags. It is always 0 when `fifoMode` is 0.
- R7: Status bit 5 equals `txHoldEmpty`. Status bit 6 is 1 only when both `txHoldEmpty` and `txShiftEmpty` are 1.
- R8: `lsIrq` is 1 exactly when `lsIntEn` is 1 and at least one of status bits 1 to 4 is 1.
- R9: After reset the queue is empty and status bits 0 to 4 and bit 7 are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| fifoMode | input | 1 | 1: queue of DEPTH entries; 0: single-character mode |
| rxPush | input | 1 | Receiver delivers a character this cycle |
| rxData | input | DATA_W | Received character |
| rxTags | input | 3 | Error tags of the character: bit 0 parity, bit 1 framing, bit 2 break |
| rxPop | input | 1 | CPU reads the head character |
| lsrRead | input | 1 | CPU reads the line status byte |
| lsIntEn | input | 1 | Line status interrupt enable |
| txHoldEmpty | input | 1 | Transmit holding register or transmit queue is empty |
| txShiftEmpty | input | 1 | Transmit shift register is empty |
| rxDataOut | output | DATA_W | Head character, 0 when empty |
| lsr | output | 8 | Line status byte |
| lsIrq | output | 1 | Line status interrupt request |

## Verification
Push, pop and status-read strobes are registered once. Their effect on data ready, overrun, the head tags, the aggregate bit and the head data is therefore due in the first cycle after the accepting edge. Bits 5 and 6 and the interrupt request follow their inputs in the same cycle. The bench drives every stimulus just after a falling edge. At the next falling edge it compares each status field, the head data and the interrupt with a queue-based model that was updated at the rising edge in between. Every result is thus taken exactly one edge after its cause, with the combinational fields read against the inputs that are in force at that moment.

// File: rtl/rxs_pkg.sv
package rxs_pkg;

  // Error tags carried with each received character
  typedef struct packed {
    logic brk;
    logic frm;
    logic par;
  } rxTags_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic wrEn;     // store incoming character at wrIdx
    logic popEn;    // head character leaves
    logic clrHead;  // status read: wipe head tags
  } rxsStrobe_t;

endpackage

// File: rtl/rxs_ctrl.sv
module rxs_ctrl
  import rxs_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          fifoMode,
  input  logic          rxPush,
  input  logic          rxPop,
  input  logic          lsrRead,
  output rxsStrobe_t    strb,
  output logic [AW-1:0] wrIdx,
  output logic [AW-1:0] rdIdx,
  output logic          dataReady,
  output logic          fifoFull,
  output logic          overrun
);

  logic [CW-1:0] count;
  logic [CW-1:0] capacity;
  logic          ovSet;

  function automatic logic [AW-1:0] nextPtr(input logic [AW-1:0] p);
    if (p == AW'(DEPTH - 1)) return '0;
    return p + AW'(1);
  endfunction

  assign capacity  = fifoMode ? CW'(DEPTH) : CW'(1);
  assign dataReady = (count != '0);
  assign fifoFull  = (count >= capacity);

  always_comb begin
    strb.popEn   = rxPop && dataReady;
    strb.wrEn    = rxPush && (!fifoFull || strb.popEn);
    strb.clrHead = lsrRead && dataReady && !strb.popEn;
    ovSet        = rxPush && !strb.wrEn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrIdx   <= '0;
      rdIdx   <= '0;
      count   <= '0;
      overrun <= 1'b0;
    end else begin
      if (strb.wrEn)  wrIdx <= nextPtr(wrIdx);
      if (strb.popEn) rdIdx <= nextPtr(rdIdx);
      count <= count + CW'(strb.wrEn) - CW'(strb.popEn);
      if (ovSet)        overrun <= 1'b1;
      else if (lsrRead) overrun <= 1'b0;
    end
  end

endmodule

// File: rtl/rxs_data.sv
module rxs_data
  import rxs_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  rxsStrobe_t        strb,
  input  logic [AW-1:0]     wrIdx,
  input  logic [AW-1:0]     rdIdx,
  input  logic [DATA_W-1:0] wrData,
  input  rxTags_t           wrTags,
  output logic [DATA_W-1:0] headData,
  output rxTags_t           headTags,
  output logic              anyErr
);

  logic [DATA_W-1:0] dataMem [DEPTH];
  rxTags_t           tagMem  [DEPTH];
  logic [DEPTH-1:0]  errMark;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errMark <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        dataMem[i] <= '0;
        tagMem[i]  <= '0;
      end
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (strb.popEn && rdIdx == AW'(i)) errMark[i] <= 1'b0;
        if (strb.clrHead && rdIdx == AW'(i)) begin
          tagMem[i]  <= '0;
          errMark[i] <= 1'b0;
        end
        // a write to the slot wins over a clear or pop on it
        if (strb.wrEn && wrIdx == AW'(i)) begin
          dataMem[i] <= wrData;
          tagMem[i]  <= wrTags;
          errMark[i] <= |wrTags;
        end
      end
    end
  end

  assign headData = dataMem[rdIdx];
  assign headTags = tagMem[rdIdx];
  assign anyErr   = |errMark;

endmodule

// File: rtl/rx_err_status.sv
module rx_err_status
  import rxs_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fifoMode,
  input  logic              rxPush,
  input  logic [DATA_W-1:0] rxData,
  input  logic [2:0]        rxTags,
  input  logic              rxPop,
  input  logic              lsrRead,
  input  logic              lsIntEn,
  input  logic              txHoldEmpty,
  input  logic              txShiftEmpty,
  output logic [DATA_W-1:0] rxDataOut,
  output logic [7:0]        lsr,
  output logic              lsIrq
);

  rxsStrobe_t        strb;
  logic [AW-1:0]     wrIdx, rdIdx;
  logic              dataReady, fifoFull, overrun, anyErr;
  logic [DATA_W-1:0] headData;
  rxTags_t           headTags, inTags;

  assign inTags = rxTags_t'(rxTags);

  rxs_ctrl #(.DEPTH(DEPTH)) ctrl_i (
    .clk(clk), .rstN(rstN), .fifoMode(fifoMode),
    .rxPush(rxPush), .rxPop(rxPop), .lsrRead(lsrRead),
    .strb(strb), .wrIdx(wrIdx), .rdIdx(rdIdx),
    .dataReady(dataReady), .fifoFull(fifoFull), .overrun(overrun)
  );

  rxs_data #(.DEPTH(DEPTH), .DATA_W(DATA_W)) data_i (
    .clk(clk), .rstN(rstN), .strb(strb),
    .wrIdx(wrIdx), .rdIdx(rdIdx),
    .wrData(rxData), .wrTags(inTags),
    .headData(headData), .headTags(headTags), .anyErr(anyErr)
  );

  always_comb begin
    lsr[0] = dataReady;
    lsr[1] = overrun;
    lsr[2] = dataReady & headTags.par;
    lsr[3] = dataReady & headTags.frm;
    lsr[4] = dataReady & headTags.brk;
    lsr[5] = txHoldEmpty;
    lsr[6] = txHoldEmpty & txShiftEmpty;
    lsr[7] = fifoMode & anyErr;
  end

  assign rxDataOut = dataReady ? headData : '0;
  assign lsIrq     = lsIntEn & (|lsr[4:1]);

endmodule

// File: rtl/rxs_status_chk.sv
module rxs_status_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              fifoMode,
  input logic              rxPush,
  input logic              rxPop,
  input logic              lsrRead,
  input logic              fifoFull,
  input logic [DATA_W-1:0] rxDataOut,
  input logic [7:0]        lsr
);

  // R1: push into empty queue makes data ready
  a_r1_ready_after_push: assert property (@(posedge clk) disable iff (!rstN)
    (rxPush && !lsr[0]) |=> lsr[0]);

  // R2: head data holds while nothing pops
  a_r2_head_stable: assert property (@(posedge clk) disable iff (!rstN)
    (lsr[0] && !rxPop) |=> $stable(rxDataOut));

  // R3: push into full queue without pop raises overrun
  a_r3_overrun_set: assert property (@(posedge clk) disable iff (!rstN)
    (rxPush && fifoFull && !rxPop) |=> lsr[1]);

  // R3: status read clears overrun when no new overrun
  a_r3_overrun_clear: assert property (@(posedge clk) disable iff (!rstN)
    (lsrRead && !(rxPush && fifoFull && !rxPop)) |=> !lsr[1]);

  // R5: status read wipes head tags but keeps the character
  a_r5_clear_head: assert property (@(posedge clk) disable iff (!rstN)
    (lsrRead && lsr[0] && !rxPop) |=> (lsr[4:2] == 3'b000) && lsr[0]);

  // R6: single-character mode never sets aggregate bit
  a_r6_nonfifo_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (!fifoMode && $stable(fifoMode)) |-> !lsr[7]);

endmodule

bind rx_err_status rxs_status_chk #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rstN(rstN), .fifoMode(fifoMode), .rxPush(rxPush),
  .rxPop(rxPop), .lsrRead(lsrRead), .fifoFull(fifoFull),
  .rxDataOut(rxDataOut), .lsr(lsr)
);

// File: tb/rx_err_status_tb_top.sv
`timescale 1ns/1ps
module rx_err_status_tb_top;

  localparam int DEPTH = 16;
  localparam int DW    = 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          fifoMode = 1'b1;
  logic          rxPush = 1'b0;
  logic [DW-1:0] rxData = '0;
  logic [2:0]    rxTags = '0;
  logic          rxPop = 1'b0;
  logic          lsrRead = 1'b0;
  logic          lsIntEn = 1'b0;
  logic          txHoldEmpty = 1'b1;
  logic          txShiftEmpty = 1'b1;
  logic [DW-1:0] rxDataOut;
  logic [7:0]    lsr;
  logic          lsIrq;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  rx_err_status #(.DEPTH(DEPTH), .DATA_W(DW)) dut_i (
    .clk(clk), .rstN(rstN), .fifoMode(fifoMode), .rxPush(rxPush),
    .rxData(rxData), .rxTags(rxTags), .rxPop(rxPop), .lsrRead(lsrRead),
    .lsIntEn(lsIntEn), .txHoldEmpty(txHoldEmpty), .txShiftEmpty(txShiftEmpty),
    .rxDataOut(rxDataOut), .lsr(lsr), .lsIrq(lsIrq)
  );

  // reference model: queue of {tags, data}
  logic [DW+2:0] mq[$];
  bit mOvr = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      mq.delete();
      mOvr = 0;
    end else begin
      bit popOk;
      int capN;
      capN  = fifoMode ? DEPTH : 1;
      popOk = rxPop && mq.size() > 0;
      if (lsrRead && mq.size() > 0 && !popOk) mq[0][DW+2:DW] = 3'b000;
      if (lsrRead) mOvr = 0;
      if (popOk) void'(mq.pop_front());
      if (rxPush) begin
        if (mq.size() < capN) mq.push_back({rxTags, rxData});
        else mOvr = 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at cycle %0d", req, act, exp, cycles);
    end
  endtask

  task automatic compareAll();
    bit dr, anyT;
    logic [2:0] hT;
    logic [DW-1:0] hD;
    logic [7:0] eL;
    dr = mq.size() > 0;
    hT = dr ? mq[0][DW+2:DW] : 3'b000;
    hD = dr ? mq[0][DW-1:0] : '0;
    anyT = 0;
    foreach (mq[i]) if (mq[i][DW+2:DW] != 3'b000) anyT = 1;
    eL = {fifoMode && anyT, txHoldEmpty && txShiftEmpty, txHoldEmpty, hT, mOvr, dr};
    chk(lsr[0] == eL[0], "R1 data ready", lsr[0], eL[0]);
    chk(rxDataOut == hD, "R2 head data", rxDataOut, hD);
    chk(lsr[1] == eL[1], "R3 overrun", lsr[1], eL[1]);
    chk(lsr[4:2] == eL[4:2], "R4/R5 head tags", lsr[4:2], eL[4:2]);
    chk(lsr[7] == eL[7], "R6 aggregate error", lsr[7], eL[7]);
    chk(lsr[6:5] == eL[6:5], "R7 transmit empties", lsr[6:5], eL[6:5]);
    chk(lsIrq == (lsIntEn && |eL[4:1]), "R8 interrupt", lsIrq, lsIntEn && |eL[4:1]);
  endtask

  // one cycle: check current outputs, then apply new inputs
  task automatic step(input bit push, input logic [DW-1:0] d, input logic [2:0] t,
                      input bit pop, input bit rd);
    @(negedge clk);
    cycles++;
    compareAll();
    rxPush = push; rxData = d; rxTags = t; rxPop = pop; lsrRead = rd;
  endtask

  task automatic idle();
    step(0, '0, 3'b000, 0, 0);
  endtask

  task automatic drain();
    for (int i = 0; i < DEPTH + 2; i++) step(0, '0, 3'b000, 1, 1);
    idle();
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    chk(lsr[4:0] == 5'b0 && lsr[7] == 1'b0, "R9 reset status", lsr, 8'h60);
    @(negedge clk);
    rstN = 1'b1;
    idle();

    // R4: tags show only at the head
    lsIntEn = 1'b1;
    step(1, 8'h11, 3'b000, 0, 0);
    step(1, 8'h22, 3'b001, 0, 0);
    step(1, 8'h33, 3'b110, 0, 0);
    idle();
    chk(lsr[4:2] == 3'b000 && lsr[7], "R4 clean head, R6 set", lsr, 8'he1);
    step(0, '0, 3'b000, 1, 0);
    idle();
    chk(lsr[2] && rxDataOut == 8'h22, "R4 parity at head", lsr, 8'he5);
    // R5 / R6: read clears head tags, aggregate stays
    step(0, '0, 3'b000, 0, 1);
    idle();
    chk(lsr[4:2] == 3'b000 && lsr[0] && rxDataOut == 8'h22, "R5 head cleared kept", rxDataOut, 8'h22);
    chk(lsr[7] == 1'b1, "R6 aggregate stays", lsr[7], 1);
    step(0, '0, 3'b000, 1, 0);
    idle();
    chk(lsr[4:3] == 2'b11 && lsIrq, "R4 framing+break, R8 irq", lsr, 8'hf9);
    step(0, '0, 3'b000, 0, 1);
    idle();
    chk(lsr[7] == 1'b0 && !lsIrq, "R6 aggregate cleared", lsr[7], 0);
    drain();

    // R3: overrun on full queue
    for (int i = 0; i < DEPTH; i++) step(1, 8'(i + 8'h40), 3'b000, 0, 0);
    step(1, 8'hee, 3'b000, 0, 0);
    idle();
    chk(lsr[1] && lsIrq, "R3 overrun set", lsr[1], 1);
    step(0, '0, 3'b000, 0, 1);
    idle();
    chk(!lsr[1], "R3 overrun cleared", lsr[1], 0);
    chk(rxDataOut == 8'h40, "R2 order kept", rxDataOut, 8'h40);
    drain();

    // R2 / R6: single-character mode
    fifoMode = 1'b0;
    idle();
    step(1, 8'h5a, 3'b001, 0, 0);
    step(1, 8'ha5, 3'b000, 0, 0);
    idle();
    chk(lsr[1] && rxDataOut == 8'h5a && !lsr[7], "R2 single capacity, R6 zero", lsr, 8'h67);
    drain();
    fifoMode = 1'b1;
    idle();

    // R7: transmit indications
    txHoldEmpty = 1'b1; txShiftEmpty = 1'b0;
    idle();
    chk(lsr[6:5] == 2'b01, "R7 shift busy", lsr[6:5], 1);
    txHoldEmpty = 1'b0; txShiftEmpty = 1'b1;
    idle();
    chk(lsr[6:5] == 2'b00, "R7 hold busy", lsr[6:5], 0);

    // mixed traffic, model compared every cycle
    for (int i = 0; i < 4000; i++) begin
      logic [2:0] t;
      t = ($urandom_range(0, 3) == 0) ? 3'($urandom_range(1, 7)) : 3'b000;
      txHoldEmpty  = 1'($urandom);
      txShiftEmpty = 1'($urandom);
      lsIntEn      = 1'($urandom);
      step(($urandom_range(0, 9) < 6), 8'($urandom), t,
           ($urandom_range(0, 9) < 4), ($urandom_range(0, 9) < 2));
    end
    drain();

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule